// File: doc/BRIEF.md
# Timed sequence step qualifier

This block decides when one step of a supply sequencing state machine is finished. The sequencer supplies a vector of condition bits, such as supply-good flags, logic inputs and warning flags. It also supplies a select index that picks one of those bits and an invert bit that sets the wanted polarity. The block waits until the picked condition has held at the wanted level for a programmed number of microseconds. It then raises `advance` for one clock cycle so that the sequencer can move to its next state.

An internal prescaler divides the clock into 1 µs ticks. With a 19-bit delay field, delays reach past 400 ms. If the condition leaves the wanted level at any point during the delay, the prescaler and the hold counter both start again from zero.

A force input skips the qualification and produces an unconditional advance. Each time the sequencer enters a new state, it pulses `step_enter`. This clears the timer and re-arms the block, so that each state gives at most one advance.

Top module: `step_qualifier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `advance` is 0.
- R2: The evaluated condition is bit `cond_in[sel]`. Changing the other bits of `cond_in` has no effect on when `advance` rises. If the condition never reaches the wanted level and force is low, `advance` stays 0.
- R3: When `invert` is 1, the wanted level of the selected bit is 0. When `invert` is 0, the wanted level is 1.
- R4: Counting cycles from the first cycle after the `step_enter` cycle as cycle 0, suppose the condition is at the wanted level in every cycle from cycle 0. Then `advance` is 1 in cycle `delay_us*CLK_PER_US + 1`.
- R5: Suppose the condition is away from the wanted level in cycle g, and at the wanted level in every other cycle. If g is earlier than the advance would have fired, `advance` rises in cycle `g + 2 + delay_us*CLK_PER_US`.
- R6: With `delay_us` = 0, `advance` rises in the cycle after the first cycle in which the condition is at the wanted level.
- R7: When `force_adv` is 1 in a cycle after entry, `advance` is 1 in the next cycle, whatever the condition and the delay.
- R8: `advance` is high for exactly one cycle. It does not rise again until the next `step_enter`, even if the condition or force stays active.
- R9: `step_enter` clears the timer and re-arms the block. An advance that would fire in the same cycle as `step_enter` is dropped. With force held through entry, `advance` is 0 in cycle 0 and 1 in cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_in | input | NCOND | Candidate condition bits |
| sel | input | SELW | Index of the evaluated condition bit |
| invert | input | 1 | Wanted level is 0 when set |
| force_adv | input | 1 | Unconditional advance request |
| delay_us | input | DLYW | Required hold time in microseconds |
| step_enter | input | 1 | One-cycle pulse on sequencer state entry |
| advance | output | 1 | One-cycle step-complete pulse |

## Verification
The main collision is between `step_enter` and a firing advance in the same cycle. The bench provokes it by raising `force_adv` together with the entry strobe. It expects `advance` to stay low in cycle 0 and to pulse only in cycle 1.

A second overlap is between a condition drop and the cycle in which the timer would complete. The bench sweeps the drop cycle across the entire delay window. For each drop cycle it checks that the rise moves to exactly `g + 2 + D*P`.

Every trial also keeps the condition active for several cycles after the pulse. This confirms that a qualified condition that stays active does not refire.

// File: rtl/step_qualifier.sv
module step_qualifier #(
  parameter int NCOND      = 8,
  parameter int SELW       = (NCOND > 1) ? $clog2(NCOND) : 1,
  parameter int CLK_PER_US = 100,
  parameter int DLYW       = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCOND-1:0] cond_in,
  input  logic [SELW-1:0]  sel,
  input  logic             invert,
  input  logic             force_adv,
  input  logic [DLYW-1:0]  delay_us,
  input  logic             step_enter,
  output logic             advance
);
  localparam int PREW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PREW-1:0] PRE_LAST = PREW'(CLK_PER_US - 1);
  localparam logic [DLYW-1:0] HOLD_MAX = '1;

  logic [PREW-1:0] pre_cnt;
  logic [DLYW-1:0] hold_cnt;
  logic            done;
  logic            want, tick, fire;

  assign want = cond_in[sel] ^ invert;
  assign tick = (pre_cnt == PRE_LAST);
  assign fire = !done && (force_adv || (want && hold_cnt >= delay_us));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      hold_cnt <= '0;
    end else if (step_enter || !want) begin
      pre_cnt  <= '0;
      hold_cnt <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick && hold_cnt != HOLD_MAX)
        hold_cnt <= hold_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      advance <= 1'b0;
    end else if (step_enter) begin
      done    <= 1'b0;
      advance <= 1'b0;
    end else begin
      done    <= done | fire;
      advance <= fire;
    end
  end
endmodule

module step_qualifier_chk #(
  parameter int NCOND = 8,
  parameter int SELW  = 3,
  parameter int DLYW  = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCOND-1:0] cond_in,
  input logic [SELW-1:0]  sel,
  input logic             invert,
  input logic             force_adv,
  input logic             step_enter,
  input logic [DLYW-1:0]  hold_cnt,
  input logic             done,
  input logic             advance
);
  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> !advance);
  // R9
  enter_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_enter |=> !advance);
  // R7
  force_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_adv && !done && !step_enter) |=> advance);
  // R2
  cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(advance) |-> ($past(force_adv) || $past(cond_in[sel] ^ invert)));
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cond_in[sel] ^ invert) |=> hold_cnt == '0);
  // R8
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !step_enter) |=> !advance);
endmodule

bind step_qualifier step_qualifier_chk #(.NCOND(NCOND), .SELW(SELW), .DLYW(DLYW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .sel(sel), .invert(invert),
  .force_adv(force_adv), .step_enter(step_enter), .hold_cnt(hold_cnt),
  .done(done), .advance(advance));

// File: tb/step_qualifier_test.sv
module step_qualifier_test;
  localparam int CLK_HALF = 5;
  localparam int P  = 2;
  localparam int NC = 8;
  localparam int SW = 3;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic [NC-1:0] cond_in = '0;
  logic [SW-1:0] sel = '0;
  logic invert = 0, force_adv = 0, step_enter = 0;
  logic [DW-1:0] delay_us = '0;
  logic advance;
  int vecs = 0, errs = 0, cyc = 0;

  always #CLK_HALF clk = ~clk;

  step_qualifier #(.NCOND(NC), .CLK_PER_US(P), .DLYW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .sel(sel), .invert(invert),
    .force_adv(force_adv), .delay_us(delay_us), .step_enter(step_enter),
    .advance(advance));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // good: condition vector while wanted; bad: used in the drop cycle g
  task automatic trial(string req, logic [SW-1:0] s, logic inv,
                       logic [NC-1:0] good, logic [NC-1:0] bad,
                       logic frc, int d, int g, int exp);
    int first = -1, pulses = 0, lim;
    lim = (exp < 0) ? 30 : exp + 8;
    @(negedge clk);
    sel = s; invert = inv; delay_us = DW'(d); cond_in = good;
    force_adv = frc; step_enter = 1;
    @(posedge clk);
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      step_enter = 0;
      if (advance) begin
        pulses++;
        if (first < 0) first = c;
      end
      cond_in = (c == g) ? bad : good;
    end
    check(req, first, exp);
    check({req, " pulse count"}, pulses, (exp < 0) ? 0 : 1);
    force_adv = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", advance, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", advance, 0);

    // R2 R3 R4 R6 R8: select/invert/delay sweep, other bits opposite
    for (int s = 0; s < NC; s++)
      for (int inv = 0; inv < 2; inv++)
        for (int d = 0; d < 6; d += 2) begin
          logic [NC-1:0] v;
          v = inv ? '1 : '0;
          v[s] = ~v[s];
          trial("R4", SW'(s), inv[0], v, v, 1'b0, d, -1, d*P + 1);
        end

    // R2: selected bit never wanted, others wanted -> no advance
    for (int s = 0; s < NC; s++) begin
      logic [NC-1:0] v;
      v = '1; v[s] = 1'b0;
      trial("R2 unselected", SW'(s), 1'b0, v, v, 1'b0, 0, -1, -1);
    end

    // R6: zero delay
    trial("R6 zero delay", 3'd1, 1'b0, 8'h02, 8'h02, 1'b0, 0, -1, 1);

    // R5: drop in every cycle of the delay window
    for (int g = 0; g < 4*P; g++)
      trial("R5 restart", 3'd5, 1'b1, 8'h00, 8'h20, 1'b0, 4, g, g + 2 + 4*P);

    // R7 R9: force asserted with the entry strobe, condition false, long delay
    trial("R9 enter vs force", 3'd0, 1'b0, 8'h00, 8'h00, 1'b1, 200, -1, 1);
    trial("R7 force", 3'd7, 1'b1, 8'hFF, 8'hFF, 1'b1, 255, -1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule